// File: doc/BRIEF.md
# Vector Stream Load/Store Unit

This unit performs the memory transfer that may travel alongside a vector arithmetic instruction. It keeps three 32-bit stream pointers: two for input streams and one for the output stream. Each transfer reads or writes memory at one of these pointers and then advances that pointer past the data it moved. A transfer is either a single 32-bit register or a 64-bit even/odd register pair. It runs over a simple request/acknowledge memory port and uses a register-file port that offers a word view and a pair view.

The issuing pipeline presents a 3-bit transfer field. This field is taken from instruction bits {10, 9, 6}, in that order from MSB to LSB. The pipeline also presents a destination/source register number. The unit accepts the operation when it is idle, holds the memory request until it is acknowledged, and then updates the pointer. For a load, it also writes the register file in that acknowledge cycle. Software can read and replace the three pointers through a small control-register window.

Top module: `vec_stream_lsu`

## Requirements
- R1: After reset, all three pointers read 0, and `busy_o`, `mem_req_o` and `illegal_o` are low.
- R2: Control address 0x4000 selects input pointer 0, 0x4001 selects input pointer 1, and 0x4002 selects the output pointer. For a selected address, `cr_hit_o` is high and `cr_rdata_o` shows the pointer's current value combinationally, and a `cr_we_i` pulse replaces that pointer at the clock edge. For any other address, `cr_hit_o` is low, `cr_rdata_o` is 0, and a write changes nothing.
- R3: An operation is accepted when `op_valid_i` is high and `busy_o` is low. A memory transfer starts only if field bit 2 or field bit 0 is set. Otherwise no request is made.
- R4: Field 3'b001 stores register rd: `mem_we_o`=1, `mem_dbl_o`=0, address = output pointer, `mem_wdata_o`[31:0] = rd and the upper half is zero. On acknowledge, the output pointer advances by 4.
- R5: Field 3'b011 stores a pair: `mem_dbl_o`=1, `mem_wdata_o` = {register rd|1, register rd&~1}. On acknowledge, the output pointer advances by 8.
- R6: Fields 3'b100 and 3'b101 load a word from input pointer 0 or input pointer 1. In the acknowledge cycle, `rf_we_o` is high, `rf_waddr_o` = rd and `rf_wdata_o` = `mem_rdata_i`[31:0]. That pointer then advances by 4.
- R7: Fields 3'b110 and 3'b111 load a pair from input pointer 0 or input pointer 1. In the acknowledge cycle, `rf_pwe_o` is high, `rf_waddr_o` = rd, and `rf_pwdata_o` = `mem_rdata_i`. The high half goes to register rd|1 and the low half to register rd&~1. That pointer then advances by 8.
- R8: Field 3'b010 is illegal. It raises `illegal_o` for the single cycle after acceptance, makes no request, and leaves all pointers unchanged.
- R9: `busy_o` and `mem_req_o` rise in the cycle after acceptance and stay high, with a stable address, through the acknowledge cycle. A pointer changes only on an acknowledge or a control write.
- R10: An operation presented while `busy_o` is high is ignored.
- R11: When a control write and an auto-increment hit the same pointer in the same cycle, the written value is kept.
- R12: Pointers wrap modulo 2^32 when they advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation presented |
| op_lsf_i | input | 3 | Transfer field {ir[10], ir[9], ir[6]} |
| op_rd_i | input | 5 | Register number |
| busy_o | output | 1 | Transfer in progress |
| illegal_o | output | 1 | Illegal field pulse |
| cr_we_i | input | 1 | Control-register write strobe |
| cr_addr_i | input | 16 | Control-register address |
| cr_wdata_i | input | 32 | Control-register write data |
| cr_rdata_o | output | 32 | Control-register read data |
| cr_hit_o | output | 1 | Address selects a pointer |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | 32 | Word read data |
| rf_pdata_i | input | 64 | Pair read data {odd, even} |
| rf_we_o | output | 1 | Word write enable |
| rf_pwe_o | output | 1 | Pair write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 32 | Word write data |
| rf_pwdata_o | output | 64 | Pair write data {odd, even} |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_dbl_o | output | 1 | 64-bit transfer |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 64 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 64 | Memory read data |

## Verification
All six legal fields are issued against pointers at distinct bases, with acknowledge latencies from zero to three cycles. This separates a wrong pointer choice, a wrong step size and a premature pointer update. Loads into odd register numbers show whether the pair index drops the low bit. A store that follows a load shows that the load reached the register file. The illegal field, an inert field, an operation held through a busy period, a control write in the acknowledge cycle and a write near 2^32 each target one of the rules on errors, ignored input, priority and wrap. The control-register address is also swept through the three pointer slots and their two neighbours on every idle cycle.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
  localparam int unsigned PTR_N = 3;
  localparam int unsigned SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_IN0 = 2'd0;
  localparam logic [SEL_W-1:0] SEL_IN1 = 2'd1;
  localparam logic [SEL_W-1:0] SEL_OUT = 2'd2;

  typedef enum logic [2:0] {
    LSF_NONE   = 3'd0,
    LSF_ST_W   = 3'd1,
    LSF_BAD    = 3'd2,
    LSF_ST_D   = 3'd3,
    LSF_LD0_W  = 3'd4,
    LSF_LD1_W  = 3'd5,
    LSF_LD0_D  = 3'd6,
    LSF_LD1_D  = 3'd7
  } lsf_e;

  typedef struct packed {
    logic             go;
    logic             bad;
    logic             store;
    logic             dbl;
    logic [SEL_W-1:0] psel;
  } lsf_dec_t;
endpackage

// File: rtl/vsl_decode.sv
module vsl_decode
  import vsl_pkg::*;
(
  input  logic [2:0] lsf_i,
  output lsf_dec_t   dec_o
);
  lsf_e code;

  always_comb begin
    code        = lsf_e'(lsf_i);
    // bit 1 alone never starts a transfer
    dec_o.go    = lsf_i[2] | lsf_i[0];
    dec_o.bad   = (code == LSF_BAD);
    dec_o.store = (code == LSF_ST_W) || (code == LSF_ST_D);
    dec_o.dbl   = (code == LSF_ST_D) || (code == LSF_LD0_D) || (code == LSF_LD1_D);
    if (dec_o.store)   dec_o.psel = SEL_OUT;
    else if (lsf_i[0]) dec_o.psel = SEL_IN1;
    else               dec_o.psel = SEL_IN0;
  end
endmodule

// File: rtl/vsl_ptr_bank.sv
module vsl_ptr_bank
  import vsl_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 32,
  parameter int unsigned     CR_AW      = 16,
  parameter logic [CR_AW-1:0] CR_BASE   = 16'h4000,
  parameter int unsigned     WORD_BYTES = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cr_we_i,
  input  logic [CR_AW-1:0]                cr_addr_i,
  input  logic [ADDR_W-1:0]               cr_wdata_i,
  output logic [ADDR_W-1:0]               cr_rdata_o,
  output logic                            cr_hit_o,
  input  logic                            inc_i,
  input  logic [SEL_W-1:0]                inc_sel_i,
  input  logic                            inc_dbl_i,
  output logic [PTR_N-1:0][ADDR_W-1:0]    ptr_o
);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP_D = ADDR_W'(2 * WORD_BYTES);

  logic [PTR_N-1:0][ADDR_W-1:0] ptr_q;

  for (genvar g = 0; g < PTR_N; g++) begin : g_ptr
    logic wr_hit, inc_hit;
    assign wr_hit  = cr_we_i && (cr_addr_i == CR_BASE + CR_AW'(g));
    assign inc_hit = inc_i && (inc_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ptr_q[g] <= '0;
      else if (wr_hit)  ptr_q[g] <= cr_wdata_i;   // software write wins
      else if (inc_hit) ptr_q[g] <= ptr_q[g] + (inc_dbl_i ? STEP_D : STEP_W);
    end
  end

  always_comb begin
    cr_hit_o   = 1'b0;
    cr_rdata_o = '0;
    for (int i = 0; i < PTR_N; i++) begin
      if (cr_addr_i == CR_BASE + CR_AW'(i)) begin
        cr_hit_o   = 1'b1;
        cr_rdata_o = ptr_q[i];
      end
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/vsl_xfer.sv
module vsl_xfer
  import vsl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned RF_AW  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  lsf_dec_t            dec_i,
  input  logic [RF_AW-1:0]    rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   st_word_i,
  input  logic [2*WORD_W-1:0] st_pair_i,
  output logic                busy_o,
  output logic                illegal_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic                mem_dbl_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*WORD_W-1:0] mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [2*WORD_W-1:0] mem_rdata_i,
  output logic                rf_we_o,
  output logic                rf_pwe_o,
  output logic [RF_AW-1:0]    rf_waddr_o,
  output logic [WORD_W-1:0]   rf_wdata_o,
  output logic [2*WORD_W-1:0] rf_pwdata_o,
  output logic                inc_o,
  output logic [SEL_W-1:0]    inc_sel_o,
  output logic                inc_dbl_o
);
  logic                busy_q, ill_q, store_q, dbl_q;
  logic [SEL_W-1:0]    sel_q;
  logic [RF_AW-1:0]    rd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [2*WORD_W-1:0] wdata_q;
  logic                accept, done;

  assign accept = op_valid_i && !busy_q;
  assign done   = busy_q && mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ill_q   <= 1'b0;
      store_q <= 1'b0;
      dbl_q   <= 1'b0;
      sel_q   <= '0;
      rd_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ill_q <= accept && dec_i.bad;
      if (accept && dec_i.go) begin
        busy_q  <= 1'b1;
        store_q <= dec_i.store;
        dbl_q   <= dec_i.dbl;
        sel_q   <= dec_i.psel;
        rd_q    <= rd_i;
        addr_q  <= addr_i;
        wdata_q <= dec_i.dbl ? st_pair_i : {{WORD_W{1'b0}}, st_word_i};
      end else if (done) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o      = busy_q;
  assign illegal_o   = ill_q;
  assign mem_req_o   = busy_q;
  assign mem_we_o    = busy_q && store_q;
  assign mem_dbl_o   = busy_q && dbl_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  assign rf_we_o     = done && !store_q && !dbl_q;
  assign rf_pwe_o    = done && !store_q && dbl_q;
  assign rf_waddr_o  = rd_q;
  assign rf_wdata_o  = mem_rdata_i[WORD_W-1:0];
  assign rf_pwdata_o = mem_rdata_i;

  assign inc_o     = done;
  assign inc_sel_o = sel_q;
  assign inc_dbl_o = dbl_q;
endmodule

// File: rtl/vec_stream_lsu.sv
module vec_stream_lsu
  import vsl_pkg::*;
#(
  parameter int unsigned      ADDR_W  = 32,
  parameter int unsigned      WORD_W  = 32,
  parameter int unsigned      RF_AW   = 5,
  parameter int unsigned      CR_AW   = 16,
  parameter logic [CR_AW-1:0] CR_BASE = 16'h4000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [2:0]          op_lsf_i,
  input  logic [RF_AW-1:0]    op_rd_i,
  output logic                busy_o,
  output logic                illegal_o,
  input  logic                cr_we_i,
  input  logic [CR_AW-1:0]    cr_addr_i,
  input  logic [ADDR_W-1:0]   cr_wdata_i,
  output logic [ADDR_W-1:0]   cr_rdata_o,
  output logic                cr_hit_o,
  output logic [RF_AW-1:0]    rf_raddr_o,
  input  logic [WORD_W-1:0]   rf_rdata_i,
  input  logic [2*WORD_W-1:0] rf_pdata_i,
  output logic                rf_we_o,
  output logic                rf_pwe_o,
  output logic [RF_AW-1:0]    rf_waddr_o,
  output logic [WORD_W-1:0]   rf_wdata_o,
  output logic [2*WORD_W-1:0] rf_pwdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic                mem_dbl_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*WORD_W-1:0] mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [2*WORD_W-1:0] mem_rdata_i
);
  localparam int unsigned WORD_BYTES = WORD_W / 8;

  lsf_dec_t                     dec;
  logic [PTR_N-1:0][ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0]            sel_addr;
  logic                         inc;
  logic [SEL_W-1:0]             inc_sel;
  logic                         inc_dbl;

  vsl_decode i_decode (
    .lsf_i (op_lsf_i),
    .dec_o (dec)
  );

  always_comb begin
    sel_addr = '0;
    for (int i = 0; i < PTR_N; i++)
      if (dec.psel == SEL_W'(i)) sel_addr = ptr_q[i];
  end

  assign rf_raddr_o = op_rd_i;

  vsl_ptr_bank #(
    .ADDR_W     (ADDR_W),
    .CR_AW      (CR_AW),
    .CR_BASE    (CR_BASE),
    .WORD_BYTES (WORD_BYTES)
  ) i_ptr_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cr_we_i    (cr_we_i),
    .cr_addr_i  (cr_addr_i),
    .cr_wdata_i (cr_wdata_i),
    .cr_rdata_o (cr_rdata_o),
    .cr_hit_o   (cr_hit_o),
    .inc_i      (inc),
    .inc_sel_i  (inc_sel),
    .inc_dbl_i  (inc_dbl),
    .ptr_o      (ptr_q)
  );

  vsl_xfer #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .RF_AW  (RF_AW)
  ) i_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_valid_i  (op_valid_i),
    .dec_i       (dec),
    .rd_i        (op_rd_i),
    .addr_i      (sel_addr),
    .st_word_i   (rf_rdata_i),
    .st_pair_i   (rf_pdata_i),
    .busy_o      (busy_o),
    .illegal_o   (illegal_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_dbl_o   (mem_dbl_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .rf_we_o     (rf_we_o),
    .rf_pwe_o    (rf_pwe_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o),
    .rf_pwdata_o (rf_pwdata_o),
    .inc_o       (inc),
    .inc_sel_o   (inc_sel),
    .inc_dbl_o   (inc_dbl)
  );
endmodule

// File: rtl/vsl_chk.sv
module vsl_chk
  import vsl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         busy_o,
  input logic                         illegal_o,
  input logic                         mem_ack_i,
  input logic                         mem_we_o,
  input logic [ADDR_W-1:0]            mem_addr_o,
  input logic                         cr_we_i,
  input logic                         rf_we_o,
  input logic                         rf_pwe_o,
  input logic [PTR_N-1:0][ADDR_W-1:0] ptr_q
);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_ack_i |=> busy_o);

  // R9
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mem_ack_i |=> !busy_o);

  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_ack_i |=> $stable(mem_addr_o));

  // R8
  illegal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o);

  // R9
  ptr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && mem_ack_i) && !cr_we_i |=> $stable(ptr_q));

  // R6
  load_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o || rf_pwe_o) |-> (busy_o && mem_ack_i && !mem_we_o));

  // R7
  one_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, rf_pwe_o}));
endmodule

bind vec_stream_lsu vsl_chk #(.ADDR_W(ADDR_W)) i_vsl_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .illegal_o  (illegal_o),
  .mem_ack_i  (mem_ack_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .cr_we_i    (cr_we_i),
  .rf_we_o    (rf_we_o),
  .rf_pwe_o   (rf_pwe_o),
  .ptr_q      (ptr_q)
);

// File: tb/test_vec_stream_lsu.sv
module test_vec_stream_lsu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_lsf_i = '0;
  logic [4:0]  op_rd_i = '0;
  logic        busy_o, illegal_o;
  logic        cr_we_i = 1'b0;
  logic [15:0] cr_addr_i = 16'h4000;
  logic [31:0] cr_wdata_i = '0;
  logic [31:0] cr_rdata_o;
  logic        cr_hit_o;
  logic [4:0]  rf_raddr_o;
  logic [31:0] rf_rdata_i;
  logic [63:0] rf_pdata_i;
  logic        rf_we_o, rf_pwe_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic [63:0] rf_pwdata_o;
  logic        mem_req_o, mem_we_o, mem_dbl_o;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  always #2 clk_i = ~clk_i;

  vec_stream_lsu i_vec_stream_lsu (.*);

  // environment register file
  logic [31:0] rf [32];
  assign rf_rdata_i = rf[rf_raddr_o];
  assign rf_pdata_i = {rf[{rf_raddr_o[4:1], 1'b1}], rf[{rf_raddr_o[4:1], 1'b0}]};

  // reference model state
  logic [31:0] m_ptr [3];
  bit          m_busy, m_ill;
  bit   [2:0]  m_code;
  logic [4:0]  m_rd;
  logic [31:0] m_addr;
  logic [63:0] m_wd;

  int vectors = 0, miscmp = 0, cycles = 0;
  int ack_delay = 0, wait_cnt = 0, beat = 0;
  bit cr_hold = 1'b0;
  int scan = 0;

  function automatic bit f_store(bit [2:0] c); return c == 3'd1 || c == 3'd3; endfunction
  function automatic bit f_dbl(bit [2:0] c);   return c == 3'd3 || c >= 3'd6; endfunction
  function automatic int f_sel(bit [2:0] c);   return f_store(c) ? 2 : int'(c[0]); endfunction

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h1000_0000 + i * 32'h0101_0101;
    for (int i = 0; i < 3; i++) m_ptr[i] = '0;
  end

  always @(posedge clk_i) begin
    bit [2:0] c;
    bit       ill_n;
    int       s;
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) m_ptr[i] = '0;
      m_busy = 0; m_ill = 0; m_code = 0; m_rd = 0; m_addr = 0; m_wd = 0;
    end else begin
      if (rf_we_o) rf[rf_waddr_o] = rf_wdata_o;
      if (rf_pwe_o) begin
        rf[{rf_waddr_o[4:1], 1'b0}] = rf_pwdata_o[31:0];
        rf[{rf_waddr_o[4:1], 1'b1}] = rf_pwdata_o[63:32];
      end
      c = op_lsf_i;
      ill_n = 0;
      if (m_busy) begin
        if (mem_ack_i) begin
          s = f_sel(m_code);
          m_ptr[s] = m_ptr[s] + (f_dbl(m_code) ? 32'd8 : 32'd4);
          m_busy = 0;
        end
      end else if (op_valid_i) begin
        if (c == 3'd2) ill_n = 1;
        else if (c[2] | c[0]) begin
          m_busy = 1; m_code = c; m_rd = op_rd_i;
          m_addr = m_ptr[f_sel(c)];
          m_wd = f_dbl(c) ? {rf[{op_rd_i[4:1], 1'b1}], rf[{op_rd_i[4:1], 1'b0}]}
                          : {32'h0, rf[op_rd_i]};
        end
      end
      if (cr_we_i && cr_addr_i >= 16'h4000 && cr_addr_i <= 16'h4002)
        m_ptr[cr_addr_i - 16'h4000] = cr_wdata_i;
      m_ill = ill_n;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // memory responder
  always @(negedge clk_i) begin
    if (mem_req_o) begin
      if (wait_cnt >= ack_delay) begin
        mem_ack_i = 1'b1;
        mem_rdata_i = {32'hA500_0000 + beat, 32'h5A00_0000 + beat};
        beat++;
        wait_cnt = 0;
      end else begin
        mem_ack_i = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ack_i = 1'b0;
      wait_cnt = 0;
    end
  end

  // control-address sweep on idle cycles
  always @(negedge clk_i) begin
    if (!cr_hold) begin
      scan = (scan + 1) % 5;
      cr_addr_i = 16'h3FFF + 16'(scan);
    end
  end

  // per-cycle comparison
  always @(negedge clk_i) begin
    bit          e_hit, e_we, e_pwe;
    logic [31:0] e_cr;
    #1;
    cycles++;
    if (cycles > 20000) begin
      miscmp++;
      $display("FAIL R9 watchdog: actual %0d expected %0d cycles", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
    e_hit = cr_addr_i >= 16'h4000 && cr_addr_i <= 16'h4002;
    e_cr  = e_hit ? m_ptr[cr_addr_i - 16'h4000] : 32'h0;
    if (!rst_ni) begin
      // R1
      chk(!busy_o && !mem_req_o && !illegal_o, "R1", "reset outputs",
          {busy_o, mem_req_o, illegal_o}, 0);
      chk(cr_rdata_o == 32'h0, "R1", "reset pointer", cr_rdata_o, 0);
    end else begin
      chk(busy_o == m_busy, "R9", "busy", busy_o, m_busy);
      chk(mem_req_o == m_busy, "R3", "request", mem_req_o, m_busy);
      chk(illegal_o == m_ill, "R8", "illegal", illegal_o, m_ill);
      chk(cr_hit_o == e_hit, "R2", "cr hit", cr_hit_o, e_hit);
      chk(cr_rdata_o == e_cr, "R2", "cr readback", cr_rdata_o, e_cr);
      if (m_busy) begin
        chk(mem_we_o == f_store(m_code), "R4", "mem write", mem_we_o, f_store(m_code));
        chk(mem_dbl_o == f_dbl(m_code), "R5", "mem size", mem_dbl_o, f_dbl(m_code));
        chk(mem_addr_o == m_addr, "R9", "mem addr", mem_addr_o, m_addr);
        if (f_store(m_code))
          chk(mem_wdata_o == m_wd, f_dbl(m_code) ? "R5" : "R4", "store data", mem_wdata_o, m_wd);
      end
      e_we  = m_busy && mem_ack_i && !f_store(m_code) && !f_dbl(m_code);
      e_pwe = m_busy && mem_ack_i && !f_store(m_code) && f_dbl(m_code);
      chk(rf_we_o == e_we, "R6", "rf word write", rf_we_o, e_we);
      chk(rf_pwe_o == e_pwe, "R7", "rf pair write", rf_pwe_o, e_pwe);
      if (e_we) begin
        chk(rf_waddr_o == m_rd, "R6", "rf waddr", rf_waddr_o, m_rd);
        chk(rf_wdata_o == mem_rdata_i[31:0], "R6", "rf wdata", rf_wdata_o, mem_rdata_i[31:0]);
      end
      if (e_pwe) begin
        chk(rf_waddr_o == m_rd, "R7", "rf waddr", rf_waddr_o, m_rd);
        chk(rf_pwdata_o == mem_rdata_i, "R7", "rf pair data", rf_pwdata_o, mem_rdata_i);
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 20 && (busy_o || op_valid_i); i++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cr_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk_i);
    cr_hold = 1'b1; cr_addr_i = a; cr_wdata_i = d; cr_we_i = 1'b1;
    @(negedge clk_i);
    cr_we_i = 1'b0; cr_hold = 1'b0;
  endtask

  task automatic issue(logic [2:0] lsf, logic [4:0] rd, int dly);
    @(negedge clk_i);
    ack_delay = dly; op_valid_i = 1'b1; op_lsf_i = lsf; op_rd_i = rd;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);                 // R1 pointers swept at zero
    // R2 pointer setup and out-of-window writes
    cr_write(16'h4000, 32'h0000_1000);
    cr_write(16'h4001, 32'h0000_2000);
    cr_write(16'h4002, 32'h0000_8000);
    cr_write(16'h3FFF, 32'hDEAD_BEEF);
    cr_write(16'h4003, 32'hDEAD_BEEF);
    repeat (6) @(negedge clk_i);
    // R4 word stores at two latencies
    issue(3'b001, 5'd5, 0);
    issue(3'b001, 5'd6, 2);
    // R5 pair store from odd register number
    issue(3'b011, 5'd9, 1);
    // R6 word loads from both inputs
    issue(3'b100, 5'd3, 0);
    issue(3'b101, 5'd11, 3);
    // R7 pair loads, odd index drops low bit
    issue(3'b110, 5'd10, 1);
    issue(3'b111, 5'd13, 2);
    // store back loaded data
    issue(3'b001, 5'd3, 0);
    issue(3'b011, 5'd12, 0);
    // R8 illegal field, R3 inert field
    issue(3'b010, 5'd7, 0);
    issue(3'b000, 5'd7, 0);
    repeat (6) @(negedge clk_i);
    // R10 operation held through busy
    @(negedge clk_i);
    ack_delay = 3; op_valid_i = 1'b1; op_lsf_i = 3'b101; op_rd_i = 5'd20;
    @(negedge clk_i);
    op_lsf_i = 3'b011; op_rd_i = 5'd2;
    @(negedge clk_i);
    op_lsf_i = 3'b010;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    wait_idle();
    // R11 control write in ack cycle
    @(negedge clk_i);
    ack_delay = 0; op_valid_i = 1'b1; op_lsf_i = 3'b001; op_rd_i = 5'd4;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    cr_hold = 1'b1; cr_addr_i = 16'h4002; cr_wdata_i = 32'h0000_C000; cr_we_i = 1'b1;
    @(negedge clk_i);
    cr_we_i = 1'b0; cr_hold = 1'b0;
    wait_idle();
    // R12 wrap at top of address space
    cr_write(16'h4002, 32'hFFFF_FFFC);
    issue(3'b001, 5'd1, 1);
    cr_write(16'h4000, 32'hFFFF_FFF8);
    issue(3'b110, 5'd14, 0);
    repeat (8) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule